// File: doc/BRIEF.md
# External Interrupt Edge and Flag Controller

This block sits between seven external interrupt sources and the priority logic of a small 8-bit microcontroller. Each raw source is synchronized to the core clock. A per-channel polarity, which is either fixed or set by software, selects which edge counts as an event. A detected edge sets a sticky pending flag. The flag is gated by the channel's enable bit and by a global enable to form the request vector that the CPU sees. Channels 0 to 5 clear their flags by themselves when the CPU acknowledges the channel. Channel 6 clears only through a software write.

Channel 6 has two sub-sources. Each sub-source has its own enable and its own sticky sub-flag. The OR of the two sub-flags is the signal that channel 6 edge-detects. While either sub-flag stays set, the OR output cannot rise again, so channel 6 stays locked out until software has cleared both sub-flags. Two timer overflow flags are also kept here. Each is set by an overflow strobe and cleared by its acknowledge strobe.

Software reaches the block through a byte-wide register port. Reads are combinational, and writes take effect at the next clock edge. Flags are cleared by writing a one to them. A zero written to a flag bit has no effect.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, every flag, enable, sub-enable and polarity bit is 0, req_o and tmr_flag_o are 0, and every register reads 0. Status register (address 0) bits 2:0 always read 0.
- R2: Channel 4 sets its flag, status bit 5, on a rising edge at src_i[4]. A falling edge there is ignored.
- R3: Channel 5 sets its flag, status bit 6, on a falling edge at src_i[5]. A rising edge there is ignored.
- R4: Polarity register (address 4) bits 3:0 choose the edge for channels 0 to 3: 0 selects falling and 1 selects rising. The reset value selects falling. Changing a polarity bit while the input is steady creates no event. Channel 2 and 3 flags are status bits 3 and 4. Channel 0 and 1 flags are bits 0 and 1 of address 1.
- R5: A flag is set no later than three clock edges after its input changes, because of the two-stage synchronizer and the edge register.
- R6: req_o[n] is high exactly when flag n, enable bit n of address 2, and the global enable (address 2 bit 7) are all 1.
- R7: A one-cycle pulse on ack_i[n], for n = 0 to 5, clears flag n at the next edge. Channel 6 has no hardware clear.
- R8: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R9: Address 3 holds the channel 6 sub-flags in bits 1:0 (write 1 to clear) and the sub-enables in bits 5:4. sub_evt_i[j] sets sub-flag j at the next edge only if sub-enable j is 1.
- R10: The channel 6 flag (status bit 7) sets on a rising edge of the OR of the sub-flags. It remains set until software writes 1 to status bit 7.
- R11: While either sub-flag stays set, no new channel 6 event can occur. After both sub-flags are cleared, the next sub-event sets the channel 6 flag again.
- R12: When a set event and a clear (acknowledge or write) fall on the same edge, the flag ends up set.
- R13: tmr_ovf_i[j] sets timer flag j, tmr_ack_i[j] clears it, and a write of 1 to address 1 bit 2+j also clears it. The flags appear on tmr_flag_o and at address 1 bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 6 | Raw asynchronous sources for channels 0 to 5 |
| sub_evt_i | input | 2 | Synchronous event strobes for the two channel 6 sub-sources |
| ack_i | input | 6 | CPU acknowledge strobes for channels 0 to 5 |
| tmr_ovf_i | input | 2 | Timer overflow strobes |
| tmr_ack_i | input | 2 | Timer service acknowledge strobes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| req_o | output | 7 | Gated interrupt requests, one bit per channel |
| tmr_flag_o | output | 2 | Timer overflow flags |

## Verification
The assertions check on every cycle that an edge event always leaves its flag set, even when a clear arrives on the same edge. They also check that flags 0 to 5 fall only after an acknowledge or a clearing write, and that the channel 6 flag falls only after a write. Further per-cycle checks cover the rule that the channel 6 flag rises only when the sub-flag OR was low two cycles earlier, the sub-flag and timer set and clear rules, and the global gating of requests. Only the bench scenarios can show the things that need a stimulus history: which pin edge each channel takes, the absence of spurious events after a polarity change, the lockout of channel 6 while a sub-flag lingers and its re-arming after both sub-flags are cleared, and the register bit layout.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int NUM_CH   = 7;
  localparam int NUM_AUTO = 6;
  localparam int NUM_PROG = 4;
  localparam int NUM_SUB  = 2;
  localparam int NUM_TMR  = 2;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;

  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_LOW  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_EN   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_SUB  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_POL  = 3'd4;

  // status register: channel STAT_CH_LO..6 at bits STAT_BIT_LO..7
  localparam int STAT_CH_LO  = 2;
  localparam int STAT_BIT_LO = 3;
  localparam int TMR_BIT_LO  = 2;
  localparam int SUB_EN_LO   = 4;
  localparam int GIE_BIT     = DATA_W - 1;

  typedef enum logic [1:0] {
    POL_PROG = 2'd0,
    POL_RISE = 2'd1,
    POL_FALL = 2'd2
  } pol_mode_e;

  function automatic pol_mode_e chan_mode(input int ch);
    if (ch < NUM_PROG) return POL_PROG;
    else if (ch == 5)  return POL_FALL;
    else               return POL_RISE;
  endfunction

  function automatic int clr_bit(input int ch);
    if (ch < STAT_CH_LO) return ch;
    else                 return ch - STAT_CH_LO + STAT_BIT_LO;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/xirq_edge_flag.sv
module xirq_edge_flag
  import xirq_pkg::*;
#(
  parameter pol_mode_e MODE = POL_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic pol_rise_i,
  input  logic clr_i,
  output logic set_o,
  output logic flag_o
);
  logic prev_q, flag_q, inv;

  always_comb begin
    case (MODE)
      POL_RISE: inv = 1'b0;
      POL_FALL: inv = 1'b1;
      default:  inv = ~pol_rise_i;
    endcase
  end

  // raw history kept, both samples mapped by current polarity: no false event on polarity change
  assign set_o = (sig_i ^ inv) & ~(prev_q ^ inv);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sig_i;
      flag_q <= set_o | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/xirq_sub_or.sv
module xirq_sub_or #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o,
  output logic         any_o
);
  logic [N-1:0] flag_q;

  for (genvar j = 0; j < N; j++) begin : g_sub
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[j] <= 1'b0;
      else         flag_q[j] <= (evt_i[j] & en_i[j]) | (flag_q[j] & ~clr_i[j]);
    end
  end

  assign flag_o = flag_q;
  assign any_o  = |flag_q;
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_AUTO-1:0] src_i,
  input  logic [NUM_SUB-1:0]  sub_evt_i,
  input  logic [NUM_AUTO-1:0] ack_i,
  input  logic [NUM_TMR-1:0]  tmr_ovf_i,
  input  logic [NUM_TMR-1:0]  tmr_ack_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic [NUM_CH-1:0]   req_o,
  output logic [NUM_TMR-1:0]  tmr_flag_o
);
  localparam int CH6 = NUM_CH - 1;

  logic [NUM_AUTO-1:0] src_s;
  logic [NUM_CH-1:0]   flag, set_ev, clr, sw_clr;
  logic [NUM_CH-1:0]   en_q;
  logic                gie_q;
  logic [NUM_PROG-1:0] pol_q;
  logic [NUM_SUB-1:0]  sub_en_q, sub_flag, sub_clr;
  logic                sub_or;
  logic [NUM_TMR-1:0]  tmr_q;
  logic                wr_stat, wr_low, wr_en, wr_sub, wr_pol;

  assign wr_stat = reg_we_i && (reg_addr_i == ADR_STAT);
  assign wr_low  = reg_we_i && (reg_addr_i == ADR_LOW);
  assign wr_en   = reg_we_i && (reg_addr_i == ADR_EN);
  assign wr_sub  = reg_we_i && (reg_addr_i == ADR_SUB);
  assign wr_pol  = reg_we_i && (reg_addr_i == ADR_POL);

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      if (k < STAT_CH_LO) sw_clr[k] = wr_low  & reg_wdata_i[clr_bit(k)];
      else                sw_clr[k] = wr_stat & reg_wdata_i[clr_bit(k)];
    end
  end

  xirq_sync #(
    .W      (NUM_AUTO),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_i),
    .q_o    (src_s)
  );

  for (genvar k = 0; k < NUM_AUTO; k++) begin : g_ch
    localparam pol_mode_e MODE = chan_mode(k);
    logic pol_rise;
    if (MODE == POL_PROG) begin : g_prog
      assign pol_rise = pol_q[k];
    end else begin : g_fixed
      assign pol_rise = 1'b0;
    end

    assign clr[k] = ack_i[k] | sw_clr[k];

    xirq_edge_flag #(
      .MODE (MODE)
    ) u_flag (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sig_i      (src_s[k]),
      .pol_rise_i (pol_rise),
      .clr_i      (clr[k]),
      .set_o      (set_ev[k]),
      .flag_o     (flag[k])
    );
  end

  // channel 6: OR of two sticky sub-flags, edge detected, software clear only
  for (genvar j = 0; j < NUM_SUB; j++) begin : g_subclr
    assign sub_clr[j] = wr_sub & reg_wdata_i[j];
  end

  xirq_sub_or #(
    .N (NUM_SUB)
  ) u_sub (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (sub_evt_i),
    .en_i   (sub_en_q),
    .clr_i  (sub_clr),
    .flag_o (sub_flag),
    .any_o  (sub_or)
  );

  assign clr[CH6] = sw_clr[CH6];

  xirq_edge_flag #(
    .MODE (POL_RISE)
  ) u_flag6 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sig_i      (sub_or),
    .pol_rise_i (1'b0),
    .clr_i      (clr[CH6]),
    .set_o      (set_ev[CH6]),
    .flag_o     (flag[CH6])
  );

  for (genvar j = 0; j < NUM_TMR; j++) begin : g_tmr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           tmr_q[j] <= 1'b0;
      else if (tmr_ovf_i[j]) tmr_q[j] <= 1'b1;
      else if (tmr_ack_i[j] | (wr_low & reg_wdata_i[TMR_BIT_LO+j]))
                             tmr_q[j] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      gie_q    <= 1'b0;
      pol_q    <= '0;
      sub_en_q <= '0;
    end else begin
      if (wr_en) begin
        en_q  <= reg_wdata_i[NUM_CH-1:0];
        gie_q <= reg_wdata_i[GIE_BIT];
      end
      if (wr_pol) pol_q    <= reg_wdata_i[NUM_PROG-1:0];
      if (wr_sub) sub_en_q <= reg_wdata_i[SUB_EN_LO +: NUM_SUB];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADR_STAT: begin
        for (int k = STAT_CH_LO; k < NUM_CH; k++) reg_rdata_o[clr_bit(k)] = flag[k];
      end
      ADR_LOW: begin
        for (int k = 0; k < STAT_CH_LO; k++) reg_rdata_o[clr_bit(k)] = flag[k];
        reg_rdata_o[TMR_BIT_LO +: NUM_TMR] = tmr_q;
      end
      ADR_EN: begin
        reg_rdata_o[NUM_CH-1:0] = en_q;
        reg_rdata_o[GIE_BIT]    = gie_q;
      end
      ADR_SUB: begin
        reg_rdata_o[NUM_SUB-1:0]           = sub_flag;
        reg_rdata_o[SUB_EN_LO +: NUM_SUB]  = sub_en_q;
      end
      ADR_POL:  reg_rdata_o[NUM_PROG-1:0] = pol_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign req_o      = flag & en_q & {NUM_CH{gie_q}};
  assign tmr_flag_o = tmr_q;
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
  import xirq_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_AUTO-1:0] ack_i,
  input logic                reg_we_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [DATA_W-1:0]   reg_wdata_i,
  input logic [NUM_CH-1:0]   flag,
  input logic [NUM_CH-1:0]   set_ev,
  input logic [NUM_SUB-1:0]  sub_flag,
  input logic [NUM_SUB-1:0]  sub_en_q,
  input logic [NUM_SUB-1:0]  sub_evt_i,
  input logic                sub_or,
  input logic                gie_q,
  input logic [NUM_CH-1:0]   req_o,
  input logic [NUM_TMR-1:0]  tmr_ovf_i,
  input logic [NUM_TMR-1:0]  tmr_ack_i,
  input logic [NUM_TMR-1:0]  tmr_flag_o
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] ADR = (k < STAT_CH_LO) ? ADR_LOW : ADR_STAT;
    localparam int BIT = clr_bit(k);

    // R12
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_ev[k] |=> flag[k]);

    if (k < NUM_AUTO) begin : g_auto
      // R7
      auto_clear_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag[k]) |-> $past(ack_i[k]) ||
          $past(reg_we_i && reg_addr_i == ADR && reg_wdata_i[BIT]));
    end else begin : g_ch6
      // R10
      ch6_sw_clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag[k]) |-> $past(reg_we_i && reg_addr_i == ADR && reg_wdata_i[BIT]));
      // R11
      ch6_lockout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag[k]) |-> !$past(sub_or, 2));
    end
  end

  for (genvar j = 0; j < NUM_SUB; j++) begin : g_sub
    // R9
    sub_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sub_evt_i[j] && sub_en_q[j]) |=> sub_flag[j]);
    // R9
    sub_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sub_flag[j]) |-> $past(sub_en_q[j]));
  end

  for (genvar j = 0; j < NUM_TMR; j++) begin : g_tmr
    // R13
    tmr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmr_ovf_i[j] |=> tmr_flag_o[j]);
    // R13
    tmr_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tmr_ack_i[j] && !tmr_ovf_i[j]) |=> !tmr_flag_o[j]);
  end

  // R6
  req_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o != '0) |-> gie_q);
endmodule

bind xirq_ctrl xirq_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ack_i       (ack_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .flag        (flag),
  .set_ev      (set_ev),
  .sub_flag    (sub_flag),
  .sub_en_q    (sub_en_q),
  .sub_evt_i   (sub_evt_i),
  .sub_or      (sub_or),
  .gie_q       (gie_q),
  .req_o       (req_o),
  .tmr_ovf_i   (tmr_ovf_i),
  .tmr_ack_i   (tmr_ack_i),
  .tmr_flag_o  (tmr_flag_o)
);

// File: tb/xirq_ctrl_test.sv
module xirq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] src_i = '0;
  logic [1:0] sub_evt_i = '0;
  logic [5:0] ack_i = '0;
  logic [1:0] tmr_ovf_i = '0;
  logic [1:0] tmr_ack_i = '0;
  logic       reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [6:0] req_o;
  logic [1:0] tmr_flag_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int         kind;   // 0 register read, 1 request vector, 2 timer flags
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xirq_ctrl uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .sub_evt_i   (sub_evt_i),
    .ack_i       (ack_i),
    .tmr_ovf_i   (tmr_ovf_i),
    .tmr_ack_i   (tmr_ack_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .req_o       (req_o),
    .tmr_flag_o  (tmr_flag_o)
  );

  // monitor: compares one queued expectation per cycle, just after the edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0:       act = reg_rdata_o;
          1:       act = {1'b0, req_o};
          default: act = {6'b0, tmr_flag_o};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i);
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    reg_addr_i = a;
    push(0, exp, tag);
  endtask

  task automatic chk_req(input logic [6:0] exp, input string tag);
    @(negedge clk_i);
    push(1, {1'b0, exp}, tag);
  endtask

  task automatic chk_tmr(input logic [1:0] exp, input string tag);
    @(negedge clk_i);
    push(2, {6'b0, exp}, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_src(input int k, input logic v);
    @(negedge clk_i);
    src_i[k] = v;
    idle(4);
  endtask

  task automatic ack(input int k);
    @(negedge clk_i);
    ack_i[k] = 1'b1;
    @(negedge clk_i);
    ack_i[k] = 1'b0;
    idle(1);
  endtask

  task automatic sub_pulse(input int j);
    @(negedge clk_i);
    sub_evt_i[j] = 1'b1;
    @(negedge clk_i);
    sub_evt_i[j] = 1'b0;
    idle(3);
  endtask

  task automatic tmr_strobe(input logic [1:0] ovf, input logic [1:0] tack);
    @(negedge clk_i);
    tmr_ovf_i = ovf; tmr_ack_i = tack;
    @(negedge clk_i);
    tmr_ovf_i = '0; tmr_ack_i = '0;
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R1 reset state
    for (int a = 0; a < 5; a++) chk_rd(3'(a), 8'h00, "R1 reset register");
    chk_req(7'h00, "R1 reset req");
    chk_tmr(2'b00, "R1 reset timer");

    // R2 channel 4 rising edge at pin; R5 latency bound
    @(negedge clk_i);
    src_i[4] = 1'b1;
    idle(3);
    chk_rd(0, 8'h20, "R2 R5 ch4 rising sets");
    idle(1);
    // R8 write of zero has no effect
    wr(0, 8'h00);
    chk_rd(0, 8'h20, "R8 zero write keeps flag");
    wr(0, 8'h20);
    chk_rd(0, 8'h00, "R8 w1c clears ch4");
    set_src(4, 1'b0);
    chk_rd(0, 8'h00, "R2 ch4 falling ignored");

    // R3 channel 5 falling edge at pin
    set_src(5, 1'b1);
    chk_rd(0, 8'h00, "R3 ch5 rising ignored");
    set_src(5, 1'b0);
    chk_rd(0, 8'h40, "R3 ch5 falling sets");
    wr(0, 8'h40);

    // R4 programmable polarity, channel 2
    set_src(2, 1'b1);
    chk_rd(0, 8'h00, "R4 ch2 default ignores rising");
    set_src(2, 1'b0);
    chk_rd(0, 8'h08, "R4 ch2 default falling sets");
    wr(0, 8'h08);
    wr(4, 8'h04);
    chk_rd(4, 8'h04, "R4 polarity readback");
    idle(3);
    chk_rd(0, 8'h00, "R4 no event from polarity change");
    set_src(2, 1'b1);
    chk_rd(0, 8'h08, "R4 ch2 rising mode sets");
    wr(0, 8'h08);
    set_src(2, 1'b0);
    chk_rd(0, 8'h00, "R4 ch2 rising mode ignores falling");

    // R4 channel 3 at status bit 4, channels 0 and 1 in low register
    set_src(3, 1'b1);
    set_src(3, 1'b0);
    chk_rd(0, 8'h10, "R4 ch3 falling sets bit 4");
    wr(0, 8'h10);
    set_src(0, 1'b1);
    set_src(0, 1'b0);
    chk_rd(1, 8'h01, "R4 ch0 flag bit 0");
    set_src(1, 1'b1);
    set_src(1, 1'b0);
    chk_rd(1, 8'h03, "R4 ch1 flag bit 1");

    // R7 acknowledge clears
    ack(0);
    chk_rd(1, 8'h02, "R7 ack clears ch0");
    ack(1);
    chk_rd(1, 8'h00, "R7 ack clears ch1");

    // R6 request gating
    set_src(4, 1'b1);
    chk_rd(0, 8'h20, "R2 ch4 set again");
    wr(2, 8'h10);
    chk_req(7'h00, "R6 no global enable");
    wr(2, 8'h90);
    chk_req(7'h10, "R6 enabled request");
    wr(2, 8'h80);
    chk_req(7'h00, "R6 channel enable off");
    wr(2, 8'h90);
    chk_rd(2, 8'h90, "R6 enable readback");

    // R12 edge and acknowledge on the same clock edge
    set_src(4, 1'b0);
    @(negedge clk_i);
    src_i[4] = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    ack_i[4] = 1'b1;
    @(negedge clk_i);
    ack_i[4] = 1'b0;
    idle(2);
    chk_rd(0, 8'h20, "R12 set wins over ack");
    chk_req(7'h10, "R12 request still raised");
    ack(4);
    chk_rd(0, 8'h00, "R7 ack clears ch4");

    // R13 timer flags
    tmr_strobe(2'b01, 2'b00);
    chk_tmr(2'b01, "R13 timer 0 set");
    chk_rd(1, 8'h04, "R13 timer 0 readable");
    tmr_strobe(2'b00, 2'b01);
    chk_tmr(2'b00, "R13 timer 0 ack clears");
    tmr_strobe(2'b10, 2'b00);
    chk_rd(1, 8'h08, "R13 timer 1 set");
    wr(1, 8'h08);
    chk_tmr(2'b00, "R13 timer 1 w1c");
    tmr_strobe(2'b01, 2'b01);
    chk_tmr(2'b01, "R12 timer set wins over ack");
    tmr_strobe(2'b00, 2'b01);

    // R9 sub-sources of channel 6
    sub_pulse(0);
    chk_rd(3, 8'h00, "R9 disabled sub-source ignored");
    chk_rd(0, 8'h00, "R9 ch6 untouched while disabled");
    wr(3, 8'h30);
    chk_rd(3, 8'h30, "R9 sub-enable readback");
    sub_pulse(0);
    chk_rd(3, 8'h31, "R9 sub-flag 0 set");

    // R10 channel 6 flag, no hardware clear
    chk_rd(0, 8'h80, "R10 ch6 set on OR rise");
    idle(10);
    chk_rd(0, 8'h80, "R10 ch6 holds");
    wr(2, 8'hC0);
    chk_req(7'h40, "R6 ch6 request");

    // R11 lockout and re-arm
    wr(0, 8'h80);
    chk_rd(0, 8'h00, "R10 ch6 w1c");
    sub_pulse(1);
    chk_rd(3, 8'h33, "R9 sub-flag 1 set");
    chk_rd(0, 8'h00, "R11 locked out while sub-flag held");
    wr(3, 8'h31);
    chk_rd(3, 8'h32, "R9 sub-flag 0 w1c");
    chk_rd(0, 8'h00, "R11 still locked with one sub-flag");
    wr(3, 8'h32);
    chk_rd(3, 8'h30, "R9 sub-flag 1 w1c");
    chk_rd(0, 8'h00, "R11 clearing does not raise ch6");
    sub_pulse(0);
    chk_rd(0, 8'h80, "R11 re-armed after both cleared");
    chk_req(7'h40, "R11 request after re-arm");

    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule